// File: doc/BRIEF.md
# Scripted Bus-Port Test Sequencer

This block is a small instruction-driven controller that drives the control side of a bus port during bring-up and soak testing. It steps through a fixed program held in an internal ROM. Each instruction is a multi-cycle primitive with its own per-cycle output sequence: prepare the port, enable reception of every message, pulse the stop line, hand a read or write request to a separate request issuer, idle for a number of cycles, wait on the two status bits, and jump. The outputs are a request-control register with a load strobe, a parameter register, a send line, four preloaded data lanes and a start/done handshake toward the request issuer.

The stored program prepares the port once and then loops forever through a read of address 01234567h and a write of address 01ABCDEFh. After each request it waits for a received message, clears that indication, and waits for the sent indication. Formatting of the request packet and the bus itself live outside this block, in the request issuer.

Top module: `bps_seq_top`

## Requirements
- R1: With `rst_n` low at a rising clock edge, every output register clears to 0 and the program restarts at entry 0 on the first edge with `rst_n` high.
- R2: The preparation step takes one cycle. It clears `req_reg` and `param_reg` and sets `send_line` and `load`. It loads lane i (bits i*32 upward of `lane_data`) with the nibble i+1 repeated, which gives 11111111h, 22222222h, 33333333h and 44444444h.
- R3: The receive-all step takes one cycle. It sets `param_reg` bit 13 and leaves the other bits as they are.
- R4: The stop step lasts 18 cycles. `load` is high in the first 17. The stop bit (`req_reg` bit 6) is low in cycles 0 to 4 and high in cycles 5 to 16. Both `load` and the stop bit are low after cycle 17, and the program then advances.
- R5: A request step first outputs one cycle with `issue_start`=1, `load`=1 and the send bit (`req_reg` bit 5)=1. In that same cycle `req_reg[2:0]` is 3'b001 for a read and 3'b111 for a write, `issue_write` shows the kind (1 = write), and `issue_addr` shows the address operand. On the next cycle `issue_start` and the send bit return to 0.
- R6: On each cycle after the start cycle, the step samples `issue_done`. It keeps `load` high until it sees `issue_done`, then drops `load` and advances. `issue_start` is not raised again while it waits.
- R7: The wait-received step holds while `status[1]` is low. After the edge on which `status[1]` is high, the clear bit (`req_reg` bit 9) and `load` are both 1. After the next edge the clear bit is 0 and `load` is still 1. After the edge after that, `load` is 0 and the program advances.
- R8: The wait-sent step holds while `status[0]` is low and advances on the edge where `status[0]` is high.
- R9: The wait step with operand N occupies N+1 cycles (N = `WAIT_N` in the stored program).
- R10: An opcode the decoder does not know takes one cycle, changes no output, and advances.
- R11: A jump takes one cycle and reloads the instruction pointer from its operand. The program order is: prepare, receive-all, stop, read 01234567h (the restart entry), wait-received, wait-sent, write 01ABCDEFh, wait-received, wait-sent, an undecoded opcode, wait N, jump to the restart entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status | input | 2 | Bit 0: message sent; bit 1: message received |
| issue_done | input | 1 | Request issuer reports the request complete |
| req_reg | output | REQ_W | Request-control register (mode bits 2:0, send 5, stop 6, clear 9) |
| load | output | 1 | Load strobe for the request-control register |
| param_reg | output | PARAM_W | Parameter register (bit 13 = receive all) |
| send_line | output | 1 | Send line, high once prepared |
| lane_data | output | LANES*LANE_W | Preloaded data lanes, lane 0 in the low bits |
| issue_start | output | 1 | One-cycle request start toward the issuer |
| issue_write | output | 1 | Request kind: 1 write, 0 read |
| issue_addr | output | 32 | Request address |

## Verification
The bench builds the block with `WAIT_N`=3 and the default widths. With the short idle step, each pass around the loop stays brief, so four full passes fit. Each pass uses a different issuer latency (0 to 3 cycles) and a different status delay for the read and the write. This reaches the case where done arrives on the cycle right after start, the long waits, and the exact gap between the wait-sent advance and the next read start across the undecoded opcode, the idle step and the jump. A reset in the middle of a run then shows that the prepare and receive-all steps replay from entry 0.

// File: rtl/bps_pkg.sv
// Package: shared opcodes, instruction and action types, and the fixed
// bit positions used by the bus-port test sequencer.
// Assumes request registers at least 10 bits and parameter registers at least 14 bits wide.
package bps_pkg;

    localparam int ARG_W     = 32;
    localparam int PROG_LEN  = 12;
    localparam int RESTART   = 3;

    localparam int REQ_SEND_BIT  = 5;
    localparam int REQ_STOP_BIT  = 6;
    localparam int REQ_CLR_BIT   = 9;
    localparam int PAR_ALLRX_BIT = 13;

    typedef logic [3:0] opcode_t;
    localparam opcode_t OP_PREP  = 4'd0;
    localparam opcode_t OP_RXALL = 4'd1;
    localparam opcode_t OP_STOP  = 4'd2;
    localparam opcode_t OP_READ  = 4'd3;
    localparam opcode_t OP_WRITE = 4'd4;
    localparam opcode_t OP_IDLE  = 4'd5;
    localparam opcode_t OP_WSENT = 4'd6;
    localparam opcode_t OP_WRECV = 4'd7;
    localparam opcode_t OP_JUMP  = 4'd8;
    localparam opcode_t OP_SPARE = 4'd12;

    typedef struct packed {
        opcode_t            op;
        logic [ARG_W-1:0]   arg;
    } instr_t;

    typedef enum logic [1:0] {NX_STAY, NX_INC, NX_ADV, NX_JMP} nxt_e;

    typedef struct packed {
        nxt_e nxt;
        logic prep;
        logic allrx;
        logic load_we;
        logic load_v;
        logic stop_we;
        logic stop_v;
        logic clr_we;
        logic clr_v;
        logic send_drop;
        logic issue;
        logic is_write;
    } act_t;

endpackage

// File: rtl/bps_prog_rom.sv
// Program ROM: maps the instruction pointer to the fixed test program.
// Assumes PTR_W covers PROG_LEN entries; out-of-range entries jump to restart.
module bps_prog_rom
    import bps_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int WAIT_N = 7
) (
    input  logic [PTR_W-1:0] idx,
    output instr_t           ins
);

    // Purpose: combinational lookup of the stored program entry.
    always_comb begin
        case (int'(idx))
            0:       ins = '{op: OP_PREP,  arg: '0};
            1:       ins = '{op: OP_RXALL, arg: '0};
            2:       ins = '{op: OP_STOP,  arg: '0};
            3:       ins = '{op: OP_READ,  arg: 32'h0123_4567};
            4:       ins = '{op: OP_WRECV, arg: '0};
            5:       ins = '{op: OP_WSENT, arg: '0};
            6:       ins = '{op: OP_WRITE, arg: 32'h01AB_CDEF};
            7:       ins = '{op: OP_WRECV, arg: '0};
            8:       ins = '{op: OP_WSENT, arg: '0};
            9:       ins = '{op: OP_SPARE, arg: '0};
            10:      ins = '{op: OP_IDLE,  arg: ARG_W'(WAIT_N)};
            default: ins = '{op: OP_JUMP,  arg: ARG_W'(RESTART)};
        endcase
    end

endmodule

// File: rtl/bps_decode.sv
// Decoder: turns the current instruction, its cycle count and the inputs
// into one cycle's action (register writes and the pointer move).
// Assumes CNT_W holds both the stop window length and the idle operand.
module bps_decode
    import bps_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int STOP_LOW  = 5,
    parameter int STOP_END  = 16
) (
    input  instr_t           ins,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       status,
    input  logic             issue_done,
    output act_t             act
);

    // Purpose: per-opcode, per-count action selection.
    always_comb begin
        act     = '0;
        act.nxt = NX_ADV;
        case (ins.op)
            OP_PREP: begin
                act.prep    = 1'b1;
                act.load_we = 1'b1;
                act.load_v  = 1'b1;
            end
            OP_RXALL: act.allrx = 1'b1;
            OP_STOP: begin
                act.load_we = 1'b1;
                act.stop_we = 1'b1;
                if (int'(cnt) < STOP_LOW) begin
                    act.load_v = 1'b1;
                    act.nxt    = NX_INC;
                end else if (int'(cnt) <= STOP_END) begin
                    act.load_v = 1'b1;
                    act.stop_v = 1'b1;
                    act.nxt    = NX_INC;
                end
            end
            OP_READ, OP_WRITE: begin
                act.load_we = 1'b1;
                if (cnt == '0) begin
                    act.issue    = 1'b1;
                    act.is_write = (ins.op == OP_WRITE);
                    act.load_v   = 1'b1;
                    act.nxt      = NX_INC;
                end else begin
                    act.send_drop = 1'b1;
                    act.load_v    = !issue_done;
                    act.nxt       = issue_done ? NX_ADV : NX_STAY;
                end
            end
            OP_IDLE:  act.nxt = (ARG_W'(cnt) < ins.arg) ? NX_INC : NX_ADV;
            OP_WSENT: act.nxt = status[0] ? NX_ADV : NX_STAY;
            OP_WRECV: begin
                if (cnt == '0) begin
                    act.clr_we  = status[1];
                    act.clr_v   = 1'b1;
                    act.load_we = status[1];
                    act.load_v  = 1'b1;
                    act.nxt     = status[1] ? NX_INC : NX_STAY;
                end else if (cnt == CNT_W'(1)) begin
                    act.clr_we = 1'b1;
                    act.nxt    = NX_INC;
                end else begin
                    act.load_we = 1'b1;
                end
            end
            OP_JUMP:  act.nxt = NX_JMP;
            default:  act.nxt = NX_ADV;
        endcase
    end

endmodule

// File: rtl/bps_pc.sv
// Program counter: instruction pointer and per-instruction cycle counter.
// Assumes the counter restarts at 0 on every advance or jump.
module bps_pc
    import bps_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  nxt_e             nxt,
    input  logic [PTR_W-1:0] jmp_tgt,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(PROG_LEN - 1);

    // Purpose: move the pointer and counter as the action selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            cnt <= '0;
        end else begin
            case (nxt)
                NX_STAY: ;
                NX_INC:  cnt <= cnt + CNT_W'(1);
                NX_ADV: begin
                    ptr <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
                    cnt <= '0;
                end
                default: begin
                    ptr <= jmp_tgt;
                    cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bps_outregs.sv
// Output registers: applies decoded actions to the request, parameter,
// send, lane and issuer-handshake registers. All clear on reset.
module bps_outregs
    import bps_pkg::*;
#(
    parameter int REQ_W   = 16,
    parameter int PARAM_W = 16,
    parameter int LANES   = 4,
    parameter int LANE_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  act_t                    act,
    input  logic [ARG_W-1:0]        arg,
    output logic [REQ_W-1:0]        req_reg,
    output logic                    load,
    output logic [PARAM_W-1:0]      param_reg,
    output logic                    send_line,
    output logic [LANES*LANE_W-1:0] lane_data,
    output logic                    issue_start,
    output logic                    issue_write,
    output logic [ARG_W-1:0]        issue_addr
);

    logic [LANES*LANE_W-1:0] seed;

    // One repeated-nibble pattern per lane: lane i gets nibble i+1.
    for (genvar i = 0; i < LANES; i++) begin : g_seed
        assign seed[i*LANE_W +: LANE_W] = {(LANE_W/4){4'(i + 1)}};
    end

    // Purpose: request-control register and its load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_reg <= '0;
            load    <= 1'b0;
        end else begin
            if (act.prep) req_reg <= '0;
            if (act.stop_we) req_reg[REQ_STOP_BIT] <= act.stop_v;
            if (act.clr_we)  req_reg[REQ_CLR_BIT]  <= act.clr_v;
            if (act.send_drop) req_reg[REQ_SEND_BIT] <= 1'b0;
            if (act.issue) begin
                req_reg[2:0]          <= act.is_write ? 3'b111 : 3'b001;
                req_reg[REQ_SEND_BIT] <= 1'b1;
            end
            if (act.load_we) load <= act.load_v;
        end
    end

    // Purpose: parameter register, send line and data lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            param_reg <= '0;
            send_line <= 1'b0;
            lane_data <= '0;
        end else if (act.prep) begin
            param_reg <= '0;
            send_line <= 1'b1;
            lane_data <= seed;
        end else if (act.allrx) begin
            param_reg[PAR_ALLRX_BIT] <= 1'b1;
        end
    end

    // Purpose: start pulse, request kind and address toward the issuer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_start <= 1'b0;
            issue_write <= 1'b0;
            issue_addr  <= '0;
        end else begin
            issue_start <= act.issue;
            if (act.issue) begin
                issue_write <= act.is_write;
                issue_addr  <= arg;
            end
        end
    end

endmodule

// File: rtl/bps_seq_top.sv
// Top: scripted bus-port test sequencer. Reads the fixed program from the
// ROM, decodes one action per cycle, and updates pointer and outputs.
// Assumes status and issue_done are synchronous to clk.
module bps_seq_top
    import bps_pkg::*;
#(
    parameter int WAIT_N   = 7,
    parameter int STOP_LOW = 5,
    parameter int STOP_END = 16,
    parameter int REQ_W    = 16,
    parameter int PARAM_W  = 16,
    parameter int LANES    = 4,
    parameter int LANE_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              status,
    input  logic                    issue_done,
    output logic [REQ_W-1:0]        req_reg,
    output logic                    load,
    output logic [PARAM_W-1:0]      param_reg,
    output logic                    send_line,
    output logic [LANES*LANE_W-1:0] lane_data,
    output logic                    issue_start,
    output logic                    issue_write,
    output logic [ARG_W-1:0]        issue_addr
);

    localparam int PTR_W   = $clog2(PROG_LEN);
    localparam int CNT_MAX = (STOP_END + 1 > WAIT_N) ? STOP_END + 1 : WAIT_N;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;
    instr_t           ins;
    act_t             act;

    bps_prog_rom #(.PTR_W(PTR_W), .WAIT_N(WAIT_N)) u_rom (
        .idx(ptr_q), .ins(ins)
    );

    bps_decode #(.CNT_W(CNT_W), .STOP_LOW(STOP_LOW), .STOP_END(STOP_END)) u_dec (
        .ins(ins), .cnt(cnt_q), .status(status), .issue_done(issue_done), .act(act)
    );

    bps_pc #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .nxt(act.nxt),
        .jmp_tgt(ins.arg[PTR_W-1:0]), .ptr(ptr_q), .cnt(cnt_q)
    );

    bps_outregs #(.REQ_W(REQ_W), .PARAM_W(PARAM_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .act(act), .arg(ins.arg),
        .req_reg(req_reg), .load(load), .param_reg(param_reg),
        .send_line(send_line), .lane_data(lane_data),
        .issue_start(issue_start), .issue_write(issue_write), .issue_addr(issue_addr)
    );

endmodule

// File: rtl/bps_seq_chk.sv
// Checker: temporal properties of the sequencer outputs, bound to the top.
module bps_seq_chk
    import bps_pkg::*;
#(
    parameter int REQ_W = 16,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REQ_W-1:0] req_reg,
    input logic             load,
    input logic             issue_start,
    input logic [ARG_W-1:0] issue_addr,
    input logic [PTR_W-1:0] ptr
);

    assert_stop_under_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_reg[REQ_STOP_BIT] |-> load);

    assert_clr_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_reg[REQ_CLR_BIT] |=> !req_reg[REQ_CLR_BIT]);

    assert_clr_under_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_reg[REQ_CLR_BIT] |-> load);

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_start |=> !issue_start);

    assert_start_with_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_start |-> (req_reg[REQ_SEND_BIT] && load));

    assert_addr_only_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !issue_start) |-> $stable(issue_addr));

    assert_ptr_in_program_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < PROG_LEN);

endmodule

bind bps_seq_top bps_seq_chk #(.REQ_W(REQ_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_reg(req_reg), .load(load),
    .issue_start(issue_start), .issue_addr(issue_addr), .ptr(ptr_q)
);

// File: tb/sim_bps_seq_top.sv
`timescale 1ns/100ps
module sim_bps_seq_top;

    localparam int WN = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   status = 2'b00;
    logic         issue_done = 1'b0;
    logic [15:0]  req_reg;
    logic         load;
    logic [15:0]  param_reg;
    logic         send_line;
    logic [127:0] lane_data;
    logic         issue_start;
    logic         issue_write;
    logic [31:0]  issue_addr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bps_seq_top #(.WAIT_N(WN)) u0 (
        .clk(clk), .rst_n(rst_n), .status(status), .issue_done(issue_done),
        .req_reg(req_reg), .load(load), .param_reg(param_reg),
        .send_line(send_line), .lane_data(lane_data),
        .issue_start(issue_start), .issue_write(issue_write), .issue_addr(issue_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [127:0] lanes_exp();
        logic [127:0] v = '0;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'(i + 1) * 32'h1111_1111;
        return v;
    endfunction

    task automatic check_prep(input string tag);
        chk(send_line == 1'b1, {tag, " send_line"}, send_line, 1);
        chk(lane_data == lanes_exp(), {tag, " lanes"}, lane_data, lanes_exp());
        chk(req_reg == 16'h0, {tag, " req"}, req_reg, 0);
        chk(load == 1'b1, {tag, " load"}, load, 1);
        chk(param_reg == 16'h0, {tag, " param"}, param_reg, 0);
    endtask

    // R5 / R6: start cycle, then issuer latency lat before done.
    task automatic issue_phase(input bit wr, input int lat);
        logic [31:0] a = wr ? 32'h01AB_CDEF : 32'h0123_4567;
        step();
        chk(issue_start == 1'b1, "R5 start", issue_start, 1);
        chk(req_reg[5] == 1'b1 && load == 1'b1, "R5 send+load", {req_reg[5], load}, 2'b11);
        chk(req_reg[2:0] == (wr ? 3'b111 : 3'b001), "R5 mode", req_reg[2:0], wr ? 3'b111 : 3'b001);
        chk(issue_addr == a && issue_write == wr, "R5 addr/kind", {issue_write, issue_addr}, {wr, a});
        for (int j = 0; j < lat; j++) begin
            step();
            chk(load == 1'b1 && issue_start == 1'b0 && req_reg[5] == 1'b0, "R6 waiting",
                {load, issue_start, req_reg[5]}, 3'b100);
        end
        issue_done = 1'b1;
        step();
        issue_done = 1'b0;
        chk(load == 1'b0 && issue_start == 1'b0 && req_reg[5] == 1'b0, "R6 complete",
            {load, issue_start, req_reg[5]}, 3'b000);
    endtask

    // R7: hold for m cycles, then the three-step clear.
    task automatic wrecv_phase(input int m);
        for (int j = 0; j < m; j++) begin
            step();
            chk(load == 1'b0 && req_reg[9] == 1'b0, "R7 holding", {load, req_reg[9]}, 2'b00);
        end
        status[1] = 1'b1;
        step();
        status[1] = 1'b0;
        chk(req_reg[9] == 1'b1 && load == 1'b1, "R7 clear set", {req_reg[9], load}, 2'b11);
        step();
        chk(req_reg[9] == 1'b0 && load == 1'b1, "R7 clear drop", {req_reg[9], load}, 2'b01);
        step();
        chk(req_reg[9] == 1'b0 && load == 1'b0, "R7 load drop", {req_reg[9], load}, 2'b00);
    endtask

    // R8 then idle edges (R9/R10/R11 after the second wait-sent) before next start.
    task automatic wsent_phase(input int k, input int idle, input string tag);
        for (int j = 0; j < k; j++) begin
            step();
            chk(issue_start == 1'b0, "R8 holding", issue_start, 0);
        end
        status[0] = 1'b1;
        step();
        status[0] = 1'b0;
        chk(issue_start == 1'b0, "R8 advance edge", issue_start, 0);
        for (int j = 0; j < idle; j++) begin
            step();
            chk(issue_start == 1'b0 && load == 1'b0, tag, {issue_start, load}, 2'b00);
        end
    endtask

    initial begin
        repeat (3) step();
        // R1: reset state
        chk(req_reg == 0 && load == 0 && param_reg == 0 && send_line == 0, "R1 reset ctl",
            {req_reg, load, param_reg, send_line}, 0);
        chk(lane_data == 0 && issue_start == 0 && issue_addr == 0, "R1 reset data",
            {lane_data[63:0], issue_start, issue_addr}, 0);
        rst_n = 1'b1;
        step();
        check_prep("R2");
        step();
        chk(param_reg == 16'h2000, "R3 receive-all", param_reg, 16'h2000);
        // R4: full stop window
        for (int i = 0; i < 18; i++) begin
            step();
            chk(req_reg[6] == (i >= 5 && i <= 16), "R4 stop bit", req_reg[6], (i >= 5 && i <= 16));
            chk(load == (i <= 16), "R4 load", load, (i <= 16));
        end
        // Sweep: four loop passes with varied latencies; R9 R10 R11 gap = WN+3 idle edges.
        for (int p = 0; p < 4; p++) begin
            issue_phase(1'b0, p);
            wrecv_phase(p + 1);
            wsent_phase(p, 0, "R8 direct");
            issue_phase(1'b1, 3 - p);
            wrecv_phase(3 - p);
            wsent_phase(p + 1, WN + 3, "R9 R10 R11 gap");
        end
        // R11: the jump landed on the read entry.
        step();
        chk(issue_start == 1'b1 && issue_addr == 32'h0123_4567 && issue_write == 1'b0, "R11 restart read",
            {issue_start, issue_write, issue_addr}, {2'b10, 32'h0123_4567});
        // R1: mid-run reset replays from entry 0.
        rst_n = 1'b0;
        step();
        chk(req_reg == 0 && load == 0 && send_line == 0 && param_reg == 0, "R1 mid-run clear",
            {req_reg, load, send_line, param_reg}, 0);
        rst_n = 1'b1;
        step();
        check_prep("R1 replay");
        step();
        chk(param_reg == 16'h2000, "R1 replay receive-all", param_reg, 16'h2000);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule